// File: doc/BRIEF.md
# Address-Pattern Bank Switch Controller

This block sits beside a bytewide memory on a shared bus. It chooses which one of up to sixteen 32 KB banks answers the bus, or it turns every bank off. No register is written to make the choice. The host runs a fixed series of sixteen read cycles, and the block follows the value on four address lines during each of them. Five of those reads also carry the selection: one enable bit followed by a four-bit bank number. The block waits until the whole series has been seen, then changes the selection at the end of the last read. Its outputs give the host memory the upper address bits and a flag that says whether any bank is active.

The strobes and the address inputs are treated as synchronous to `clk_i`. A read cycle is counted once, at the clock edge where its end is seen. A flag from outside, `pwr_ok_i`, reports whether the supply is good. When the flag drops, the block forgets the selection and any sequence it has only partly tracked. The parameter `NUM_BANKS` gives the number of banks fitted (2, 4, 8, 12 or 16). A code that names a bank which is not fitted turns everything off.

Top module: `bank_switch_ctrl`

## Requirements
- R1: After reset, `bank_active_o` is 0 and `bank_o` is 0.
- R2: A read cycle has ce_ni=0, oe_ni=0 and we_ni=1. It counts as one step when ce_ni or oe_ni rises while we_ni stays 1. Write cycles (we_ni=0) do not move the tracker, and neither does strobe activity while ce_ni=1.
- R3: `addr_hi_i` carries address bits 11..8 (bit 3 = A11, bit 0 = A8). Steps 0 to 10 must match all four bits exactly: 0101, 1010, 0101, 1010, 1010, 1010, 0101, 0101, 1010, 0111, 1000.
- R4: Steps 11 to 15 must match bits 3..1 exactly: 010, 010, 010, 101, 101. Bit 0 on these steps is data and never counts as a mismatch.
- R5: If bit 0 of step 11 is 0, a completed sequence turns all banks off.
- R6: Bit 0 of steps 12 to 15 gives the bank number, most significant bit first. The new selection appears only after the sixteenth read completes. Until then, the previous selection stays on the outputs.
- R7: A step that does not match returns the tracker to step 0 and leaves the selection unchanged. A complete sequence that follows is accepted.
- R8: A read of 1111 in the middle of a sequence realigns the tracker, so the next read is taken as step 0.
- R9: While `pwr_ok_i` is 0, the selection is cleared, the tracker returns to step 0, and reads are ignored. A partial sequence does not survive a power drop.
- R10: A completed selection whose bank number is NUM_BANKS or more turns all banks off.
- R11: When `bank_active_o` is 0, `bank_o` reads 0. Only one bank number is driven at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_hi_i | input | 4 | Address bits 11..8 (bit 0 = A8) |
| pwr_ok_i | input | 1 | Supply good flag |
| bank_active_o | output | 1 | A bank is selected |
| bank_o | output | 4 | Selected bank number, used as upper address |

## Verification
The assertions assume three things: every strobe and address input changes cleanly with respect to `clk_i`, the address lines hold steady for the whole of a read, and a read lasts at least one clock while its strobes are low. The bench changes its inputs only on falling clock edges. Each phase of a read or write is held for two clocks, and the address is set before the strobes fall. Random sequences, corrupted steps and writes mixed in between steps all use that same timing, so none of them reaches outside those assumptions.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int SEQ_LEN   = 16;
  localparam int STEP_W    = $clog2(SEQ_LEN);
  localparam int DATA_STEP = 11;
  localparam int PIN_W     = 4;
  localparam int BANK_W    = 4;

  typedef struct packed {
    logic              en;
    logic [BANK_W-1:0] num;
  } sel_t;

  // expected A11..A8 per step; bit 0 is don't-care from DATA_STEP on
  function automatic logic [PIN_W-1:0] step_pattern(input logic [STEP_W-1:0] s);
    case (s)
      4'd0, 4'd2, 4'd6, 4'd7:        step_pattern = 4'b0101;
      4'd1, 4'd3, 4'd4, 4'd5, 4'd8:  step_pattern = 4'b1010;
      4'd9:                          step_pattern = 4'b0111;
      4'd10:                         step_pattern = 4'b1000;
      4'd11, 4'd12, 4'd13:           step_pattern = 4'b0100;
      default:                       step_pattern = 4'b1010;
    endcase
  endfunction

  function automatic logic [PIN_W-1:0] step_mask(input logic [STEP_W-1:0] s);
    step_mask = (s >= STEP_W'(DATA_STEP)) ? 4'b1110 : 4'b1111;
  endfunction
endpackage

// File: rtl/bsw_strobe.sv
module bsw_strobe #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              pwr_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_done_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              rd_now;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;

  assign rd_now = pwr_ok_i & ~ce_ni & ~oe_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q <= rd_now;
      if (rd_now) addr_q <= addr_i;
    end
  end

  // read ends on CE or OE rise; a WE fall turns it into a write
  assign rd_done_o = rd_q & we_ni & pwr_ok_i & (ce_ni | oe_ni);
  assign addr_o    = addr_q;
endmodule

// File: rtl/bsw_seq.sv
module bsw_seq
  import bsw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_ok_i,
  input  logic             rd_done_i,
  input  logic [PIN_W-1:0] addr_i,
  output logic             commit_o,
  output sel_t             sel_o
);
  localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(SEQ_LEN - 1);
  localparam logic [STEP_W-1:0] FIRST_DATA = STEP_W'(DATA_STEP);

  logic [STEP_W-1:0] step_q;
  logic [BANK_W-1:0] code_q;
  logic              hit;

  assign hit = ((addr_i ^ step_pattern(step_q)) & step_mask(step_q)) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      code_q <= '0;
    end else if (!pwr_ok_i) begin
      step_q <= '0;
      code_q <= '0;
    end else if (rd_done_i) begin
      if (!hit || step_q == LAST_STEP) step_q <= '0;
      else                             step_q <= step_q + 1'b1;
      if (hit && step_q >= FIRST_DATA) code_q <= {code_q[BANK_W-2:0], addr_i[0]};
    end
  end

  assign commit_o  = rd_done_i & hit & (step_q == LAST_STEP);
  assign sel_o.en  = code_q[BANK_W-1];
  assign sel_o.num = {code_q[BANK_W-2:0], addr_i[0]};

  // R2: tracker only moves on a completed read or a power drop
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pwr_ok_i) && !$past(rd_done_i)) |-> $stable(step_q));

  // R3: tracker steps forward by one or falls back to zero
  p_step_walk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(step_q) |-> (step_q == '0 || step_q == $past(step_q) + STEP_W'(1)));

  // R9: power drop clears the tracker
  p_pwr_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> step_q == '0);
endmodule

// File: rtl/bsw_bank.sv
module bsw_bank
  import bsw_pkg::*;
#(
  parameter int NUM_BANKS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              commit_i,
  input  sel_t              sel_i,
  output logic              active_o,
  output logic [BANK_W-1:0] bank_o
);
  localparam logic [BANK_W:0] LIMIT = (BANK_W + 1)'(NUM_BANKS);

  logic accept;

  generate
    if (NUM_BANKS >= (1 << BANK_W)) begin : g_full
      assign accept = sel_i.en;
    end else begin : g_part
      assign accept = sel_i.en && ({1'b0, sel_i.num} < LIMIT);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      bank_o   <= '0;
    end else if (!pwr_ok_i) begin
      active_o <= 1'b0;
      bank_o   <= '0;
    end else if (commit_i) begin
      active_o <= accept;
      bank_o   <= accept ? sel_i.num : '0;
    end
  end

  // R10: never drives a bank that is not fitted
  p_in_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> ({1'b0, bank_o} < LIMIT));

  // R11: idle output reads zero
  p_off_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> bank_o == '0);

  // R9: supply loss drops the selection
  p_pwr_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> !active_o);
endmodule

// File: rtl/bank_switch_ctrl.sv
module bank_switch_ctrl
  import bsw_pkg::*;
#(
  parameter int NUM_BANKS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [PIN_W-1:0]  addr_hi_i,
  input  logic              pwr_ok_i,
  output logic              bank_active_o,
  output logic [BANK_W-1:0] bank_o
);
  logic             rd_done;
  logic [PIN_W-1:0] rd_addr;
  logic             commit;
  sel_t             sel;

  bsw_strobe #(.ADDR_W(PIN_W)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .pwr_ok_i (pwr_ok_i),
    .addr_i   (addr_hi_i),
    .rd_done_o(rd_done),
    .addr_o   (rd_addr)
  );

  bsw_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_ok_i (pwr_ok_i),
    .rd_done_i(rd_done),
    .addr_i   (rd_addr),
    .commit_o (commit),
    .sel_o    (sel)
  );

  bsw_bank #(.NUM_BANKS(NUM_BANKS)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_ok_i (pwr_ok_i),
    .commit_i (commit),
    .sel_i    (sel),
    .active_o (bank_active_o),
    .bank_o   (bank_o)
  );

  // R6: outputs move only after a completed sequence or a power drop
  p_change_on_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({bank_active_o, bank_o}) |-> ($past(commit) || !$past(pwr_ok_i)));
endmodule

// File: tb/sim_bank_switch_ctrl.sv
module sim_bank_switch_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pwr = 1'b1;
  logic [3:0] a = 4'h0;
  logic       act0, act1;
  logic [3:0] bk0, bk1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit e0_act = 1'b0, e1_act = 1'b0;
  logic [3:0] e0_bk = 4'h0, e1_bk = 4'h0;

  always #4 clk = ~clk;

  bank_switch_ctrl #(.NUM_BANKS(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_hi_i(a), .pwr_ok_i(pwr), .bank_active_o(act0), .bank_o(bk0));

  bank_switch_ctrl #(.NUM_BANKS(12)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_hi_i(a), .pwr_ok_i(pwr), .bank_active_o(act1), .bank_o(bk1));

  function automatic logic [3:0] pat(input int s, input bit en, input logic [3:0] b);
    logic [3:0] v;
    case (s)
      0, 2, 6, 7:    v = 4'b0101;
      1, 3, 4, 5, 8: v = 4'b1010;
      9:             v = 4'b0111;
      10:            v = 4'b1000;
      11:            v = {3'b010, en};
      12:            v = {3'b010, b[3]};
      13:            v = {3'b010, b[2]};
      14:            v = {3'b101, b[1]};
      default:       v = {3'b101, b[0]};
    endcase
    return v;
  endfunction

  function automatic logic [3:0] corrupt(input int s, input logic [3:0] v);
    if (s < 11) return v ^ 4'($urandom_range(1, 15));
    return v ^ {3'($urandom_range(1, 7)), 1'b0};
  endfunction

  task automatic expect_sel(input bit en, input logic [3:0] b);
    e0_act = en;
    e0_bk  = en ? b : 4'h0;
    e1_act = en && (b < 4'd12);
    e1_bk  = e1_act ? b : 4'h0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] v, input bit via_oe);
    a = v; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    tick(2);
    if (via_oe) begin oe_n = 1'b1; tick(1); ce_n = 1'b1; end
    else begin ce_n = 1'b1; tick(1); oe_n = 1'b1; end
    tick(2);
  endtask

  task automatic wr(input logic [3:0] v);
    a = v; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    tick(2);
    ce_n = 1'b1; we_n = 1'b1;
    tick(2);
  endtask

  task automatic noise(input logic [3:0] v);
    a = v; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    tick(2);
    oe_n = 1'b1;
    tick(2);
  endtask

  // steps lo..hi; bad_at replaces that step and stops; mix adds writes/noise
  task automatic run(input bit en, input logic [3:0] b, input int lo, input int hi,
                     input int bad_at, input bit mix);
    for (int s = lo; s <= hi; s++) begin
      logic [3:0] v;
      v = pat(s, en, b);
      if (mix && $urandom_range(0, 1) == 1) wr(~v);
      if (mix && $urandom_range(0, 2) == 0) noise(~v);
      if (s == bad_at) begin
        rd(corrupt(s, v), 1'($urandom_range(0, 1)));
        return;
      end
      rd(v, mix ? 1'($urandom_range(0, 1)) : 1'b0);
    end
  endtask

  task automatic chk(input string req);
    n_chk++;
    if (act0 !== e0_act || bk0 !== e0_bk) begin
      n_bad++;
      $display("FAIL %s u0 act=%0d bank=%0d expected act=%0d bank=%0d",
               req, act0, bk0, e0_act, e0_bk);
    end
    n_chk++;
    if (act1 !== e1_act || bk1 !== e1_bk) begin
      n_bad++;
      $display("FAIL %s u1 act=%0d bank=%0d expected act=%0d bank=%0d",
               req, act1, bk1, e1_act, e1_bk);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d expected finish", act0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1217);
    tick(3);
    chk("R1 reset");
    rst_n = 1'b1;
    tick(2);
    chk("R1 after release");

    rd(4'hF, 1'b0);
    run(1'b1, 4'd7, 0, 15, -1, 1'b0);
    expect_sel(1'b1, 4'd7);
    chk("R3 R4 bank 7");

    run(1'b1, 4'd3, 0, 14, -1, 1'b0);
    chk("R6 held before last step");
    run(1'b1, 4'd3, 15, 15, -1, 1'b0);
    expect_sel(1'b1, 4'd3);
    chk("R6 bank 3 after last step");

    run(1'b1, 4'd15, 0, 15, -1, 1'b0);
    expect_sel(1'b1, 4'd15);
    chk("R10 bank 15");
    run(1'b1, 4'd12, 0, 15, -1, 1'b0);
    expect_sel(1'b1, 4'd12);
    chk("R10 bank 12");
    run(1'b1, 4'd11, 0, 15, -1, 1'b0);
    expect_sel(1'b1, 4'd11);
    chk("R10 bank 11");

    run(1'b0, 4'd9, 0, 15, -1, 1'b0);
    expect_sel(1'b0, 4'd0);
    chk("R5 R11 banks off");

    run(1'b1, 4'd9, 0, 15, -1, 1'b0);
    expect_sel(1'b1, 4'd9);
    run(1'b1, 4'd2, 0, 15, 5, 1'b0);
    chk("R7 mismatch step 5 keeps bank");
    run(1'b1, 4'd2, 0, 15, 13, 1'b0);
    chk("R7 R4 mismatch step 13 keeps bank");
    run(1'b1, 4'd2, 0, 15, -1, 1'b0);
    expect_sel(1'b1, 4'd2);
    chk("R7 recovery bank 2");

    run(1'b1, 4'd5, 0, 6, -1, 1'b0);
    rd(4'hF, 1'b1);
    run(1'b1, 4'd4, 0, 15, -1, 1'b0);
    expect_sel(1'b1, 4'd4);
    chk("R8 realign then bank 4");

    run(1'b1, 4'd13, 0, 15, -1, 1'b1);
    expect_sel(1'b1, 4'd13);
    chk("R2 writes and CE-high noise ignored");

    run(1'b1, 4'd6, 0, 15, -1, 1'b0);
    expect_sel(1'b1, 4'd6);
    pwr = 1'b0;
    tick(2);
    expect_sel(1'b0, 4'd0);
    chk("R9 power drop clears");
    run(1'b1, 4'd8, 0, 15, -1, 1'b0);
    chk("R9 reads ignored while power low");
    pwr = 1'b1;
    tick(2);
    chk("R9 stays off after power return");
    run(1'b1, 4'd1, 0, 7, -1, 1'b0);
    pwr = 1'b0;
    tick(2);
    pwr = 1'b1;
    tick(2);
    run(1'b1, 4'd10, 0, 15, -1, 1'b0);
    expect_sel(1'b1, 4'd10);
    chk("R9 partial sequence lost on power drop");

    for (int i = 0; i < 30; i++) begin
      bit         en;
      logic [3:0] b;
      int         bad;
      en  = ($urandom_range(0, 3) != 0);
      b   = 4'($urandom_range(0, 15));
      bad = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 15) : -1;
      run(en, b, 0, 15, bad, 1'($urandom_range(0, 1)));
      if (bad < 0) expect_sel(en, b);
      chk(bad < 0 ? "R6 R10 random select" : "R7 random mismatch");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule